// File: doc/BRIEF.md
# Two-Session Low-Power Scan BIST Sequencer

This block feeds the serial input of a scan chain during built-in self-test and sequences two test sessions in a fixed order. The first session shifts in patterns from a low-transition random source. This source changes the scan input value only rarely, which keeps switching in the chain low while it catches the faults that are easy to detect. The second session targets the random-pattern-resistant faults that are left after the first session. It uses a three-weight source, which pins chosen bit positions of each pattern to constant values taken from a small computed test-cube table and fills every other position with pseudo-random bits. One multiplexer in front of the chain picks the source.

Each pattern takes a fixed number of shift cycles, followed by one capture cycle in which scan-enable is low. Response compaction lives outside the block. It reports a per-capture mismatch on `respMiss`, and the block turns this into one sticky fault flag per session. A mode input decides whether the weighted session follows the first one or the run stops after the first session.

Top module: `lp_scan_bist`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the cycle right after, `scanEnable`, `scanData`, `testDone`, `faultLt` and `faultWr` are all 0.
- R2: A pattern consists of CHAIN_LEN consecutive cycles with `scanEnable`=1, followed by one capture cycle with `scanEnable`=0. Shifting of the first session starts in the second cycle after `rst` falls.
- R3: The first session applies exactly PATS_LT patterns.
- R4: In first-session shift cycles, `scanData` equals a toggle bit that is 0 after reset. At the end of each such shift cycle, the toggle bit inverts only when LFSR bits 0 and 1 are both 1.
- R5: The 16-bit LFSR holds 16'hACE1 after reset. It steps only in shift cycles of either session, as lfsr <= {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}.
- R6: `dualSession` is read in the final capture cycle of the first session. A 0 there ends the run. A 1 starts second-session shifting in the next cycle.
- R7: In the second-session shift cycle with shift index j (0 for the first bit of a pattern) and cube index c, `scanData` is (c^j)&1 when (j+c) mod 3 is 0, and lfsr[0] otherwise.
- R8: The cube index is 0 for the first second-session pattern. It increases by one per pattern and wraps after NUM_CUBES-1. The second session applies PATS_WR patterns.
- R9: `scanData` is 0 in every cycle in which `scanEnable` is 0.
- R10: `faultLt` becomes 1 in the cycle after a first-session capture cycle with `respMiss`=1, and stays 1 until reset. `respMiss` in any other cycle has no effect on it.
- R11: `faultWr` behaves the same way, but only for second-session capture cycles.
- R12: After the last session ends, `testDone` is 1 and `scanEnable` is 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dualSession | input | 1 | 1: run the weighted session after the first session |
| respMiss | input | 1 | Response mismatch reported by the external compactor, sampled in capture cycles |
| scanData | output | 1 | Serial data into the scan chain |
| scanEnable | output | 1 | 1 while shifting, 0 in capture and idle cycles |
| testDone | output | 1 | Run complete |
| faultLt | output | 1 | Sticky fault flag for the low-transition session |
| faultWr | output | 1 | Sticky fault flag for the weighted session |

## Verification
The session switch and the fault capture fall in the same cycle. The last capture of the first session both reads `dualSession` and samples `respMiss`, so a mismatch there must set `faultLt` and never `faultWr`. The bench drives `respMiss` in exactly that cycle, and also in the first capture of the weighted session and across whole shift phases. It judges every cycle against a behavioural reference model, which shows that each flag belongs to the correct session and that mismatches outside capture cycles do nothing.

// File: rtl/lp_bist_pkg.sv
package lp_bist_pkg;

  typedef enum logic [1:0] {
    SESS_IDLE = 2'd0,
    SESS_LT   = 2'd1,
    SESS_WR   = 2'd2,
    SESS_FIN  = 2'd3
  } sess_e;

  // strobes from sequencer to pattern datapath
  typedef struct packed {
    logic shift;
    logic capture;
    logic wrSel;
  } seq_strobe_t;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic logic [15:0] lfsrStep(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

  // test-cube table, computed: bit j of cube c is pinned when (j+c) mod 3 == 0
  function automatic logic cubePinned(input int c, input int j);
    return ((j + c) % 3) == 0;
  endfunction

  function automatic logic cubeValue(input int c, input int j);
    return 1'((c ^ j) & 1);
  endfunction

endpackage

// File: rtl/lp_bist_seq.sv
module lp_bist_seq
  import lp_bist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PATS_LT   = 6,
  parameter int PATS_WR   = 5,
  parameter int NUM_CUBES = 3,
  localparam int SH_W   = $clog2(CHAIN_LEN + 1),
  localparam int PMAX   = (PATS_LT > PATS_WR) ? PATS_LT : PATS_WR,
  localparam int PAT_W  = $clog2(PMAX + 1),
  localparam int CUBE_W = (NUM_CUBES > 1) ? $clog2(NUM_CUBES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dualSession,
  output seq_strobe_t       strobe,
  output logic [SH_W-1:0]   bitIdx,
  output logic [CUBE_W-1:0] cubeIdx,
  output logic              finished
);

  sess_e             sess;
  logic [SH_W-1:0]   shiftCnt;
  logic [PAT_W-1:0]  patCnt;
  logic [CUBE_W-1:0] cubeCnt;
  logic              active;
  logic              atCapture;
  logic              lastPat;

  assign active    = (sess == SESS_LT) || (sess == SESS_WR);
  assign atCapture = (shiftCnt == SH_W'(CHAIN_LEN));
  assign lastPat   = (sess == SESS_LT) ? (patCnt == PAT_W'(PATS_LT - 1))
                                       : (patCnt == PAT_W'(PATS_WR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sess     <= SESS_IDLE;
      shiftCnt <= '0;
      patCnt   <= '0;
      cubeCnt  <= '0;
    end else begin
      unique case (sess)
        SESS_IDLE: sess <= SESS_LT;
        SESS_LT, SESS_WR: begin
          if (!atCapture) begin
            shiftCnt <= shiftCnt + 1'b1;
          end else begin
            shiftCnt <= '0;
            if (sess == SESS_WR)
              cubeCnt <= (cubeCnt == CUBE_W'(NUM_CUBES - 1)) ? '0 : cubeCnt + 1'b1;
            if (lastPat) begin
              patCnt <= '0;
              if (sess == SESS_LT && dualSession) sess <= SESS_WR;
              else                                sess <= SESS_FIN;
            end else begin
              patCnt <= patCnt + 1'b1;
            end
          end
        end
        default: sess <= SESS_FIN;
      endcase
    end
  end

  always_comb begin
    strobe.shift   = active && !atCapture;
    strobe.capture = active && atCapture;
    strobe.wrSel   = (sess == SESS_WR);
  end

  assign bitIdx   = shiftCnt;
  assign cubeIdx  = cubeCnt;
  assign finished = (sess == SESS_FIN);

  AST_SESS_ORDER: assert property (@(posedge clk) disable iff (rst)
    (sess == SESS_WR) |=> (sess == SESS_WR || sess == SESS_FIN)); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sess == SESS_FIN) |=> (sess == SESS_FIN && !strobe.shift)); // R12

  AST_CAP_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (strobe.shift || sess == SESS_FIN)); // R2

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.shift, strobe.capture})); // R2

endmodule

// File: rtl/lp_bist_dp.sv
module lp_bist_dp
  import lp_bist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_CUBES = 3,
  localparam int SH_W   = $clog2(CHAIN_LEN + 1),
  localparam int CUBE_W = (NUM_CUBES > 1) ? $clog2(NUM_CUBES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       strobe,
  input  logic [SH_W-1:0]   bitIdx,
  input  logic [CUBE_W-1:0] cubeIdx,
  input  logic              respMiss,
  output logic              scanData,
  output logic              scanEnable,
  output logic              faultLt,
  output logic              faultWr
);

  logic [15:0] lfsr;
  logic        togBit;
  logic        togHit;
  logic        wrBit;

  assign togHit = lfsr[0] & lfsr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= LFSR_SEED;
      togBit  <= 1'b0;
      faultLt <= 1'b0;
      faultWr <= 1'b0;
    end else begin
      if (strobe.shift) begin
        lfsr <= lfsrStep(lfsr);
        if (!strobe.wrSel && togHit) togBit <= ~togBit;
      end
      if (strobe.capture && respMiss) begin
        if (strobe.wrSel) faultWr <= 1'b1;
        else              faultLt <= 1'b1;
      end
    end
  end

  always_comb begin
    if (cubePinned(int'(cubeIdx), int'(bitIdx)))
      wrBit = cubeValue(int'(cubeIdx), int'(bitIdx));
    else
      wrBit = lfsr[0];
  end

  // source multiplexer in front of the chain
  assign scanData   = strobe.shift ? (strobe.wrSel ? wrBit : togBit) : 1'b0;
  assign scanEnable = strobe.shift;

  AST_LT_RARE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !strobe.wrSel && !togHit) |=> $stable(togBit)); // R4

  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strobe.shift |=> $stable(lfsr)); // R5

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'h0000); // R5

  AST_FLT_STICKY: assert property (@(posedge clk) disable iff (rst)
    faultLt |=> faultLt); // R10

  AST_FWR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(faultWr) |-> $past(strobe.capture && strobe.wrSel && respMiss)); // R11

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !scanEnable |-> !scanData); // R9

endmodule

// File: rtl/lp_scan_bist.sv
module lp_scan_bist
  import lp_bist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PATS_LT   = 6,
  parameter int PATS_WR   = 5,
  parameter int NUM_CUBES = 3,
  localparam int SH_W   = $clog2(CHAIN_LEN + 1),
  localparam int CUBE_W = (NUM_CUBES > 1) ? $clog2(NUM_CUBES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic dualSession,
  input  logic respMiss,
  output logic scanData,
  output logic scanEnable,
  output logic testDone,
  output logic faultLt,
  output logic faultWr
);

  seq_strobe_t       strobe;
  logic [SH_W-1:0]   bitIdx;
  logic [CUBE_W-1:0] cubeIdx;

  lp_bist_seq #(
    .CHAIN_LEN(CHAIN_LEN), .PATS_LT(PATS_LT),
    .PATS_WR(PATS_WR), .NUM_CUBES(NUM_CUBES)
  ) uSeq (
    .clk(clk), .rst(rst), .dualSession(dualSession),
    .strobe(strobe), .bitIdx(bitIdx), .cubeIdx(cubeIdx),
    .finished(testDone)
  );

  lp_bist_dp #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_CUBES(NUM_CUBES)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .bitIdx(bitIdx),
    .cubeIdx(cubeIdx), .respMiss(respMiss), .scanData(scanData),
    .scanEnable(scanEnable), .faultLt(faultLt), .faultWr(faultWr)
  );

endmodule

// File: tb/tb_lp_scan_bist.sv
module tb_lp_scan_bist;

  localparam int L  = 8;
  localparam int PL = 6;
  localparam int PW = 5;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dualSession = 1'b0;
  logic respMiss = 1'b0;
  logic scanData, scanEnable, testDone, faultLt, faultWr;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  lp_scan_bist #(.CHAIN_LEN(L), .PATS_LT(PL), .PATS_WR(PW), .NUM_CUBES(NC)) dut (
    .clk(clk), .rst(rst), .dualSession(dualSession), .respMiss(respMiss),
    .scanData(scanData), .scanEnable(scanEnable), .testDone(testDone),
    .faultLt(faultLt), .faultWr(faultWr)
  );

  // behavioural reference: phase 0 idle, 1 first session, 2 weighted, 3 finished
  int          mPhase = 0;
  int          mStep = 0;
  int          mPat = 0;
  int          mCube = 0;
  logic [15:0] mRand = 16'hACE1;
  logic        mTog = 1'b0;
  logic        mF1 = 1'b0;
  logic        mF2 = 1'b0;

  function automatic logic refEn();
    return (mPhase == 1 || mPhase == 2) && mStep < L;
  endfunction

  function automatic logic refData();
    if (!refEn()) return 1'b0;
    if (mPhase == 1) return mTog;
    if (((mStep + mCube) % 3) == 0) return 1'((mCube ^ mStep) & 1);
    return mRand[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mStep = 0; mPat = 0; mCube = 0;
      mRand = 16'hACE1; mTog = 1'b0; mF1 = 1'b0; mF2 = 1'b0;
    end else if (mPhase == 0) begin
      mPhase = 1;
    end else if (mPhase == 1 || mPhase == 2) begin
      if (mStep < L) begin
        if (mPhase == 1 && mRand[0] && mRand[1]) mTog = ~mTog;
        mRand = {mRand[14:0], mRand[15] ^ mRand[13] ^ mRand[12] ^ mRand[10]};
        mStep++;
      end else begin
        if (respMiss) begin
          if (mPhase == 1) mF1 = 1'b1; else mF2 = 1'b1;
        end
        mStep = 0;
        if (mPhase == 2) mCube = (mCube + 1) % NC;
        mPat++;
        if (mPhase == 1 && mPat == PL) begin
          mPat = 0; mPhase = dualSession ? 2 : 3;
        end else if (mPhase == 2 && mPat == PW) begin
          mPat = 0; mPhase = 3;
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  int capSeen = 0;
  logic prevEn = 1'b0;

  // policy bits: 0 miss in shift cycles, 1 last capture of first session,
  // 2 first capture of weighted session, 3 first capture of first session
  task automatic runCycles(input int n, input int policy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2 scanEnable", scanEnable, refEn());
      if (!refEn())        check("R9 scanData idle", scanData, refData());
      else if (mPhase == 1) check("R4,R5 scanData", scanData, refData());
      else                  check("R7,R8 scanData", scanData, refData());
      check("R6,R12 testDone", testDone, mPhase == 3);
      check("R10 faultLt", faultLt, mF1);
      check("R11 faultWr", faultWr, mF2);
      if (prevEn && !scanEnable) capSeen++;
      prevEn = scanEnable;
      respMiss = 1'b0;
      if (policy[0] && refEn()) respMiss = 1'b1;
      if (policy[1] && mPhase == 1 && mStep == L && mPat == PL - 1) respMiss = 1'b1;
      if (policy[2] && mPhase == 2 && mStep == L && mPat == 0) respMiss = 1'b1;
      if (policy[3] && mPhase == 1 && mStep == L && mPat == 0) respMiss = 1'b1;
    end
  endtask

  task automatic doReset();
    rst = 1'b1; respMiss = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 scanEnable", scanEnable, 1'b0);
    check("R1 scanData", scanData, 1'b0);
    check("R1 testDone", testDone, 1'b0);
    check("R1 flags", faultLt | faultWr, 1'b0);
    rst = 1'b0;
    capSeen = 0; prevEn = 1'b0;
  endtask

  initial begin
    // run A: single session, mismatch at first capture and in shift cycles
    dualSession = 1'b0;
    doReset();
    runCycles(70, 32'h9);
    check("R3 capture count", capSeen == PL, 1'b1);
    check("R6 stop after first session", testDone, 1'b1);
    check("R11 no weighted flag", faultWr, 1'b0);

    // run B: both sessions, mismatch exactly at the session switch
    dualSession = 1'b1;
    doReset();
    runCycles(60, 32'h2);
    check("R10 flag at switch", faultLt, 1'b1);
    check("R11 not at switch", faultWr, 1'b0);
    runCycles(60, 32'h4);
    check("R8 capture count both", capSeen == PL + PW, 1'b1);
    check("R11 weighted flag", faultWr, 1'b1);

    // run C: both sessions, misses only during shifting (ignored)
    doReset();
    runCycles(120, 32'h1);
    check("R10 shift miss ignored", faultLt, 1'b0);
    check("R11 shift miss ignored", faultWr, 1'b0);
    check("R12 done holds", testDone & ~scanEnable, 1'b1);

    // run D: reset in the middle of the weighted session
    doReset();
    runCycles(75, 32'h0);
    doReset();
    runCycles(20, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule